// File: doc/BRIEF.md
# FIFO Status Calendar Generator

This block produces the receive-side flow-control stream of a SPI-4.2 style link. On every status clock it drives a 2-bit word toward the data source. The words tell the source how much room each receive FIFO has left. A frame starts with the framing word `11`. When calendar switching is enabled, a word naming the calendar set in use follows the framing word. Then come the status words of the calendar slots: the slot list is walked from slot 0 to the last slot, and that walk is repeated M times. A 2-bit DIP-2 check word closes the frame, and the next frame follows straight after it.

Each calendar slot points to a port through a small internal slot-to-port table. The word sent for a slot is the live 2-bit status of that port. The calendar length and the repetition count come from a main set of inputs. When switching is enabled they can come from a shadow set instead. The choice is captured once per frame. While the link is disabled, or while the receive data path is not aligned, the block sends only `11`.

Top module: `fifo_stat_cal`

## Requirements
- R1: After a clock edge with `rst` high, and for as long as `rx_aligned` stays low, `stat_o` is `11` on every cycle.
- R2: If `stat_dis` is high or `rx_aligned` is low at a clock edge, from any state, `stat_o` is `11` from that edge on, and stays `11` until the block is re-enabled.
- R3: At the first edge where `stat_dis` is low and `rx_aligned` is high after a disabled period, the block emits the framing word `11` for exactly one cycle.
- R4: At the edge that ends a framing word, the block captures the calendar length and repetition count M. With `sw_en` low it takes `len_main`/`m_main`. With `sw_en` high it takes the shadow set if `cal_sel` is 1 and the main set if `cal_sel` is 0. Changes to these inputs at any other time do not alter the frame in progress. Both values must be at least 1.
- R5: A calendar word is the status of the port that the table assigns to the current slot. Port p's status is `port_stat[2p+1:2p]`, with 00 starving, 01 hungry and 10 satisfied. The block emits one word per cycle for slots 0 to length-1, and repeats that sequence M times.
- R6: A write with `tbl_we` high at a clock edge sets the port of slot `tbl_addr` to `tbl_port` from that edge on. After reset, slot i points to port i mod NPORT.
- R7: The check word is A XOR `11`. A is cleared by the framing word. Then, for every word w emitted after it, A becomes {A[0],A[1]} XOR w.
- R8: When the edge ending a framing word sees `sw_en` high, one extra word `{0, cal_sel}` precedes the calendar words. This word is included in the parity.
- R9: The cycle after a check word carries the next framing word, so frames follow each other without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_dis | input | 1 | Forces the idle pattern `11` |
| rx_aligned | input | 1 | Receive data path alignment flag |
| sw_en | input | 1 | Calendar switching enable |
| cal_sel | input | 1 | Set select when switching: 1 shadow, 0 main |
| len_main | input | LEN_W | Main calendar length |
| m_main | input | M_W | Main repetition count |
| len_shd | input | LEN_W | Shadow calendar length |
| m_shd | input | M_W | Shadow repetition count |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_addr | input | LEN_W | Slot index to write |
| tbl_port | input | clog2(NPORT) | Port number for that slot |
| port_stat | input | 2*NPORT | Live 2-bit status per port |
| stat_o | output | 2 | Status bus |

## Verification
The two functions that can meet in one cycle are the disable/misalignment override and the frame sequencer's last steps: a halt can land on the edge where the check word would go out, or where the framing word would restart the frame. The bench provokes this by pulsing `stat_dis` or dropping `rx_aligned` for a single cycle, then waiting a different number of cycles before the next pulse, so that the pulses sweep across every position of a short frame. A behavioural token-queue model, rebuilt at each framing word, gives the expected word for every cycle. It judges that `11` appears from the halting edge on, and that the next frame starts with exactly one framing word and carries fresh parity.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FRAME,
        ST_SETW,
        ST_SLOT,
        ST_CHECK
    } fsc_state_e;

    localparam logic [1:0] IDLE_WORD = 2'b11;

    // one diagonal parity step: rotate the running code, fold in a word
    function automatic logic [1:0] dip2_step(logic [1:0] acc, logic [1:0] w);
        return {acc[0], acc[1]} ^ w;
    endfunction

endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
    import fsc_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int M_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             sw_en,
    input  logic             cal_sel,
    input  logic [LEN_W-1:0] len_main,
    input  logic [M_W-1:0]   m_main,
    input  logic [LEN_W-1:0] len_shd,
    input  logic [M_W-1:0]   m_shd,
    output fsc_state_e       state,
    output logic [LEN_W-1:0] slot_idx,
    output logic             set_q
);

    logic [LEN_W-1:0] len_q;
    logic [M_W-1:0]   rep_q;
    logic             use_shd;
    logic             last_slot;

    assign use_shd   = sw_en & cal_sel;
    assign last_slot = (slot_idx == len_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OFF;
            slot_idx <= '0;
            len_q    <= '0;
            rep_q    <= '0;
            set_q    <= 1'b0;
        end else if (halt) begin
            state <= ST_OFF;
        end else begin
            case (state)
                ST_OFF:   state <= ST_FRAME;
                ST_FRAME: begin
                    slot_idx <= '0;
                    set_q    <= use_shd;
                    len_q    <= use_shd ? len_shd : len_main;
                    rep_q    <= (use_shd ? m_shd : m_main) - M_W'(1);
                    state    <= sw_en ? ST_SETW : ST_SLOT;
                end
                ST_SETW:  state <= ST_SLOT;
                ST_SLOT: begin
                    if (last_slot) begin
                        slot_idx <= '0;
                        if (rep_q == '0) state <= ST_CHECK;
                        else             rep_q <= rep_q - M_W'(1);
                    end else begin
                        slot_idx <= slot_idx + LEN_W'(1);
                    end
                end
                ST_CHECK: state <= ST_FRAME;
                default:  state <= ST_OFF;
            endcase
        end
    end

    // R3: framing word lasts one cycle
    p_frame_single_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME && !halt) |=> (state != ST_FRAME));

    // R9: check word is followed by a framing word
    p_check_then_frame_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && !halt) |=> (state == ST_FRAME));

    // R5: slot index stays inside the captured calendar
    p_slot_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT) |-> (slot_idx < len_q));

endmodule

// File: rtl/fsc_slot_table.sv
module fsc_slot_table #(
    parameter int NPORT  = 4,
    parameter int LEN_W  = 4,
    parameter int PORT_W = $clog2(NPORT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [LEN_W-1:0]   waddr,
    input  logic [PORT_W-1:0]  wport,
    input  logic [LEN_W-1:0]   raddr,
    input  logic [2*NPORT-1:0] port_stat,
    output logic [1:0]         slot_stat
);

    localparam int SLOTS = 1 << LEN_W;

    logic [PORT_W-1:0] map_q [SLOTS];
    logic [PORT_W-1:0] sel_port;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                map_q[i] <= PORT_W'(i % NPORT);
            else if (we && waddr == LEN_W'(i))
                map_q[i] <= wport;
        end
    end

    assign sel_port  = map_q[raddr];
    assign slot_stat = port_stat[{sel_port, 1'b0} +: 2];

    // R6: a written slot holds the written port afterwards
    p_table_write_r6: assert property (@(posedge clk) disable iff (rst)
        we |=> (map_q[$past(waddr)] == $past(wport)));

endmodule

// File: rtl/fsc_dip2.sv
module fsc_dip2
    import fsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [1:0] word,
    output logic [1:0] acc
);

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= 2'b00;
        else if (en)    acc <= dip2_step(acc, word);
    end

    // R7: the framing word starts a fresh parity
    p_clear_on_frame_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == 2'b00));

endmodule

// File: rtl/fifo_stat_cal.sv
module fifo_stat_cal
    import fsc_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int LEN_W  = 4,
    parameter int M_W    = 3,
    parameter int PORT_W = $clog2(NPORT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stat_dis,
    input  logic               rx_aligned,
    input  logic               sw_en,
    input  logic               cal_sel,
    input  logic [LEN_W-1:0]   len_main,
    input  logic [M_W-1:0]     m_main,
    input  logic [LEN_W-1:0]   len_shd,
    input  logic [M_W-1:0]     m_shd,
    input  logic               tbl_we,
    input  logic [LEN_W-1:0]   tbl_addr,
    input  logic [PORT_W-1:0]  tbl_port,
    input  logic [2*NPORT-1:0] port_stat,
    output logic [1:0]         stat_o
);

    fsc_state_e       state;
    logic [LEN_W-1:0] slot_idx;
    logic             set_q;
    logic [1:0]       slot_stat;
    logic [1:0]       acc;
    logic             halt;

    assign halt = stat_dis | ~rx_aligned;

    fsc_ctrl #(.LEN_W(LEN_W), .M_W(M_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .halt     (halt),
        .sw_en    (sw_en),
        .cal_sel  (cal_sel),
        .len_main (len_main),
        .m_main   (m_main),
        .len_shd  (len_shd),
        .m_shd    (m_shd),
        .state    (state),
        .slot_idx (slot_idx),
        .set_q    (set_q)
    );

    fsc_slot_table #(.NPORT(NPORT), .LEN_W(LEN_W), .PORT_W(PORT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .we        (tbl_we),
        .waddr     (tbl_addr),
        .wport     (tbl_port),
        .raddr     (slot_idx),
        .port_stat (port_stat),
        .slot_stat (slot_stat)
    );

    fsc_dip2 u_dip (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == ST_FRAME),
        .en   (state == ST_SETW || state == ST_SLOT),
        .word (stat_o),
        .acc  (acc)
    );

    always_comb begin
        case (state)
            ST_SETW:  stat_o = {1'b0, set_q};
            ST_SLOT:  stat_o = slot_stat;
            ST_CHECK: stat_o = acc ^ IDLE_WORD;
            default:  stat_o = IDLE_WORD;
        endcase
    end

    // R2: a halt shows as idle pattern on the next cycle
    p_halt_idle_r2: assert property (@(posedge clk) disable iff (rst)
        halt |=> (stat_o == IDLE_WORD));

endmodule

// File: tb/test_fifo_stat_cal.sv
`timescale 1ns/1ps
module test_fifo_stat_cal;

    localparam int NPORT = 4;
    localparam int LEN_W = 4;
    localparam int M_W   = 3;
    localparam int PW    = 2;

    logic             clk = 1'b0;
    logic             rst, stat_dis, rx_aligned, sw_en, cal_sel, tbl_we;
    logic [LEN_W-1:0] len_main, len_shd, tbl_addr;
    logic [M_W-1:0]   m_main, m_shd;
    logic [PW-1:0]    tbl_port;
    logic [7:0]       port_stat;
    logic [1:0]       stat_o;

    fifo_stat_cal #(.NPORT(NPORT), .LEN_W(LEN_W), .M_W(M_W)) i_fifo_stat_cal (
        .clk(clk), .rst(rst), .stat_dis(stat_dis), .rx_aligned(rx_aligned),
        .sw_en(sw_en), .cal_sel(cal_sel), .len_main(len_main), .m_main(m_main),
        .len_shd(len_shd), .m_shd(m_shd), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_port(tbl_port), .port_stat(port_stat), .stat_o(stat_o)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    fails   = 0;
    int    cycle   = 0;
    bit    started = 0;
    bit    done    = 0;
    string tag     = "R1";

    // reference model state: token queue, -1 frame, -2 set word, -3 check, >=0 slot
    int         tq[$];
    bit         m_off = 1;
    int         tblm[16];
    logic [1:0] m_acc = 2'b00;
    int         m_set = 0;

    always @(posedge clk) begin
        cycle++;
        started = 1;
        if (rst) begin
            for (int i = 0; i < 16; i++) tblm[i] = i % NPORT;
            m_off = 1;
            tq.delete();
        end else begin
            if (tbl_we) tblm[tbl_addr] = tbl_port;
            if (stat_dis || !rx_aligned) begin
                m_off = 1;
                tq.delete();
            end else if (m_off) begin
                m_off = 0;
                tq.push_back(-1);
            end else begin
                int tok;
                tok = tq.pop_front();
                if (tok == -1) begin
                    int L, M;
                    bit shd;
                    shd   = sw_en && cal_sel;
                    L     = shd ? int'(len_shd) : int'(len_main);
                    M     = shd ? int'(m_shd) : int'(m_main);
                    m_set = shd ? 1 : 0;
                    if (sw_en) tq.push_back(-2);
                    for (int r = 0; r < M; r++)
                        for (int s = 0; s < L; s++) tq.push_back(s);
                    tq.push_back(-3);
                end
                if (tq.size() == 0) tq.push_back(-1);
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            logic [1:0] exp;
            string      what;
            if (m_off) begin
                exp  = 2'b11;
                what = "idle";
            end else begin
                case (tq[0])
                    -1: begin exp = 2'b11; m_acc = 2'b00; what = "frame"; end
                    -2: begin
                        exp   = {1'b0, m_set[0]};
                        m_acc = {m_acc[0], m_acc[1]} ^ exp;
                        what  = "setword";
                    end
                    -3: begin exp = m_acc ^ 2'b11; what = "check"; end
                    default: begin
                        exp   = port_stat[2*tblm[tq[0]] +: 2];
                        m_acc = {m_acc[0], m_acc[1]} ^ exp;
                        what  = "slot";
                    end
                endcase
            end
            vectors++;
            if (stat_o !== exp) begin
                fails++;
                $display("FAIL %s (%s) cycle %0d: stat_o=%b expected %b",
                         tag, what, cycle, stat_o, exp);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] mix(input int i);
        logic [7:0] v;
        for (int k = 0; k < 4; k++) v[2*k +: 2] = 2'((i + k) % 3);
        return v;
    endfunction

    initial begin
        rst = 1; stat_dis = 0; rx_aligned = 0; sw_en = 0; cal_sel = 0;
        len_main = 3; m_main = 2; len_shd = 5; m_shd = 1;
        tbl_we = 0; tbl_addr = 0; tbl_port = 0; port_stat = 8'b10_01_00_10;
        cyc(3);
        rst = 0;
        tag = "R1";
        cyc(5);

        tag = "R5/R7/R9 main calendar";
        rx_aligned = 1;
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 0) port_stat = mix(i);
            cyc(1);
        end

        tag = "R4/R8 shadow set";
        sw_en = 1; cal_sel = 1;
        for (int i = 0; i < 40; i++) begin
            if (i == 10) begin len_main = 2; m_main = 3; end
            if (i == 13) begin len_shd = 4; m_shd = 2; end
            if (i % 4 == 1) port_stat = mix(i + 7);
            cyc(1);
        end

        tag = "R4/R8 main set with switching";
        cal_sel = 0;
        cyc(30);

        tag = "R6 table writes";
        sw_en = 0; len_main = 4; m_main = 2; port_stat = 8'b00_10_01_00;
        tbl_we = 1; tbl_addr = 0; tbl_port = 3; cyc(1);
        tbl_addr = 1; tbl_port = 3; cyc(1);
        tbl_addr = 2; tbl_port = 1; cyc(1);
        tbl_addr = 3; tbl_port = 0; cyc(1);
        tbl_we = 0;
        cyc(30);

        tag = "R2/R3 halt sweep";
        len_main = 2; m_main = 2; sw_en = 1; cal_sel = 0;
        for (int k = 0; k < 14; k++) begin
            if (k % 2 == 0) stat_dis = 1; else rx_aligned = 0;
            cyc(1);
            stat_dis = 0; rx_aligned = 1;
            cyc(3 + k);
        end
        stat_dis = 1;
        cyc(4);
        stat_dis = 0;

        tag = "R3/R5 length one";
        sw_en = 0; len_main = 1; m_main = 1;
        cyc(12);

        tag = "R5/R7 longest calendar";
        len_main = 15; m_main = 7; port_stat = mix(5);
        for (int i = 0; i < 240; i++) begin
            if (i % 11 == 0) port_stat = mix(i);
            cyc(1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cycle);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule